// File: doc/BRIEF.md
# VCO Sub-Band Search Controller

This block chooses one of a set of VCO sub-bands so that a frequency synthesizer locks with margin on both sides of its tuning range. When software writes the fractional-divider trigger while automatic selection is enabled, the controller loads a programmed starting band. It then waits a programmable number of cycles for the loop to settle and reads a 3-bit code from a tuning-voltage ADC. From that code it either stops or moves one band up or down. It stops only on the two codes that mark a tuning voltage near mid-range. Codes that mean "locked, but close to a rail" make it keep searching, so the chosen band leaves room for temperature drift.

The controller reports an idle flag, which is low while a search runs, and a success flag that is high only after a band has been found. It also reports a lock indication taken from the final code, and a readback byte that carries the band and an ADC code. With automatic selection disabled, the band follows the software value directly, and software can enable ADC readback and freeze the last reading. A mode bit decides whether the charge-pump current follows the search or a software bit.

Top module: `vco_band_search`

## Requirements
- R1: During reset, and after it until a search starts, srch_idle=1, srch_ok=0 and lock_ok=0. During reset, vco_band is the default start value 25 clamped to 23, and status_rb is 8'hB8 (band in bits 7:3, code field 000).
- R2: A search starts on a clock edge where trig_wr=1 and auto_en=1. When auto_en=0, a trigger is ignored and srch_idle stays 1. Clearing auto_en during a search ends the search in the next cycle with srch_idle=1 and srch_ok=0.
- R3: A start value above 23 is treated as 23, both as the search starting band and as the manual band. vco_band never exceeds 23.
- R4: After each load of a band (at the start or after a step), the ADC code is judged on the (settle_len+1)-th following edge. A search that judges J bands completes J*(settle_len+1) edges after the trigger edge.
- R5: A search ends successfully only when the judged code is 010 or 101. It then sets srch_ok=1 and lock_ok=1 and keeps that band.
- R6: Any other judged code moves the band by exactly one: down when the code MSB is 0 (000, 001, 011), up when the MSB is 1 (100, 110, 111).
- R7: The search fails, with srch_ok=0 and the last judged band kept, when a step would go below band 0 or above band 23, or when 24 bands have been judged without success.
- R8: srch_idle is 0 from the edge after the trigger until the search ends; srch_ok is never 1 while srch_idle is 0.
- R9: When a search ends, lock_ok is 1 exactly when the final judged code is 001, 010, 101 or 110.
- R10: status_rb = {vco_band, code field}. In automatic mode the code field is the ADC code registered on the previous edge.
- R11: With auto_en=0, vco_band follows the clamped start_band one edge later. With rd_en=1 and rd_hold=0, the code field tracks the ADC. With rd_hold=1 it freezes. With rd_en=0 it reads 000.
- R12: With cp_auto=1, cp_high is 1 exactly while a search runs. With cp_auto=0, cp_high equals cp_hi_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_wr | input | 1 | One-cycle pulse when the fraction trigger register is written |
| auto_en | input | 1 | Automatic band selection enable |
| start_band | input | 5 | Starting band (automatic) or selected band (manual) |
| settle_len | input | 8 | Settle cycles before each ADC judgement |
| adc_code | input | 3 | Tuning-voltage ADC code |
| rd_en | input | 1 | Manual-mode ADC readback enable |
| rd_hold | input | 1 | Manual-mode freeze of the readback code |
| cp_auto | input | 1 | Charge-pump current follows the search when 1 |
| cp_hi_sel | input | 1 | Charge-pump high current when cp_auto=0 |
| vco_band | output | 5 | Band driven to the VCO bank |
| srch_idle | output | 1 | 0 while a search runs |
| srch_ok | output | 1 | Last search found a band |
| lock_ok | output | 1 | Final code indicates lock |
| status_rb | output | 8 | Readback byte {band, code} |
| cp_high | output | 1 | Charge-pump high-current select |

## Verification
The hardest case to reach from the ports is the 24-judgement limit. A real VCO bank drives a search to a rail long before that. The bench therefore makes the ADC code a function of the band the controller drives, and uses a pattern that alternates "step up" and "step down" between two neighbouring bands, so that only the judgement cap can end the search. The same band-to-code mapping also covers walks toward a target, runs off either rail with locked and unlocked final codes, and an abort in the middle of a long settle window.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int CODE_W = 3;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } step_e;

  // Mid-range codes: the only ones a search may stop on
  function automatic logic code_stop(input code_t c);
    return (c == 3'b010) || (c == 3'b101);
  endfunction

  // Any code that means the loop is locked
  function automatic logic code_locked(input code_t c);
    return code_stop(c) || (c == 3'b001) || (c == 3'b110);
  endfunction

  // Non-stop codes move by MSB: 0 -> down, 1 -> up
  function automatic step_e code_dir(input code_t c);
    if (code_stop(c)) return DIR_HOLD;
    return c[CODE_W-1] ? DIR_UP : DIR_DOWN;
  endfunction
endpackage

// File: rtl/vsel_settle_timer.sv
module vsel_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/vsel_step_fsm.sv
module vsel_step_fsm
  import vsel_pkg::*;
#(
  parameter  int NBANDS    = 24,
  parameter  int DEF_START = 25,
  localparam int BAND_W    = $clog2(NBANDS),
  localparam int STEP_W    = $clog2(NBANDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              auto_en,
  input  logic [BAND_W-1:0] start_band,
  input  code_t             adc_code,
  input  logic              tick,
  output logic [BAND_W-1:0] band,
  output logic              running,
  output logic              found,
  output logic              locked,
  output logic              start_evt,
  output logic              judge_evt,
  output logic              load_evt
);
  localparam logic [BAND_W-1:0] LAST = BAND_W'(NBANDS - 1);

  function automatic logic [BAND_W-1:0] clamp_band(input logic [BAND_W-1:0] b);
    return (b > LAST) ? LAST : b;
  endfunction

  logic [BAND_W-1:0] band_q;
  logic [STEP_W-1:0] steps_q;
  logic              run_q, ok_q, lk_q;
  step_e             dir;
  logic              stop_c, edge_hit, cap_hit, fail_c, step_c;

  assign start_evt = trig && auto_en;
  assign judge_evt = run_q && auto_en && tick && !start_evt;
  assign stop_c    = code_stop(adc_code);
  assign dir       = code_dir(adc_code);
  assign edge_hit  = ((dir == DIR_DOWN) && (band_q == '0)) ||
                     ((dir == DIR_UP)   && (band_q == LAST));
  assign cap_hit   = (steps_q == STEP_W'(NBANDS - 1));
  assign fail_c    = judge_evt && !stop_c && (edge_hit || cap_hit);
  assign step_c    = judge_evt && !stop_c && !(edge_hit || cap_hit);
  assign load_evt  = start_evt || step_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      band_q  <= clamp_band(BAND_W'(DEF_START));
      steps_q <= '0;
      run_q   <= 1'b0;
      ok_q    <= 1'b0;
      lk_q    <= 1'b0;
    end else if (start_evt) begin
      band_q  <= clamp_band(start_band);
      steps_q <= '0;
      run_q   <= 1'b1;
      ok_q    <= 1'b0;
      lk_q    <= 1'b0;
    end else if (!auto_en) begin
      band_q  <= clamp_band(start_band);
      steps_q <= '0;
      run_q   <= 1'b0;
      ok_q    <= 1'b0;
      lk_q    <= 1'b0;
    end else if (judge_evt) begin
      steps_q <= steps_q + 1'b1;
      if (stop_c) begin
        run_q <= 1'b0;
        ok_q  <= 1'b1;
        lk_q  <= code_locked(adc_code);
      end else if (fail_c) begin
        run_q <= 1'b0;
        lk_q  <= code_locked(adc_code);
      end else if (dir == DIR_UP) begin
        band_q <= band_q + 1'b1;
      end else begin
        band_q <= band_q - 1'b1;
      end
    end
  end

  assign band    = band_q;
  assign running = run_q;
  assign found   = ok_q;
  assign locked  = lk_q;
endmodule

// File: rtl/vsel_readback.sv
module vsel_readback
  import vsel_pkg::*;
#(
  parameter  int BAND_W = 5,
  localparam int RB_W   = BAND_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              rd_en,
  input  logic              rd_hold,
  input  code_t             adc_code,
  input  logic [BAND_W-1:0] band,
  input  logic              running,
  input  logic              cp_auto,
  input  logic              cp_hi_sel,
  output logic [RB_W-1:0]   status,
  output logic              cp_high
);
  code_t code_q;
  logic  track, show;

  assign track = auto_en || (rd_en && !rd_hold);
  assign show  = auto_en || rd_en;

  always_ff @(posedge clk) begin
    if (!rst_n)     code_q <= '0;
    else if (track) code_q <= adc_code;
  end

  assign status  = {band, show ? code_q : code_t'(0)};
  assign cp_high = cp_auto ? running : cp_hi_sel;
endmodule

// File: rtl/vco_band_search.sv
module vco_band_search
  import vsel_pkg::*;
#(
  parameter  int NBANDS    = 24,
  parameter  int DEF_START = 25,
  parameter  int SETTLE_W  = 8,
  localparam int BAND_W    = $clog2(NBANDS),
  localparam int RB_W      = BAND_W + CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_wr,
  input  logic                auto_en,
  input  logic [BAND_W-1:0]   start_band,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [CODE_W-1:0]   adc_code,
  input  logic                rd_en,
  input  logic                rd_hold,
  input  logic                cp_auto,
  input  logic                cp_hi_sel,
  output logic [BAND_W-1:0]   vco_band,
  output logic                srch_idle,
  output logic                srch_ok,
  output logic                lock_ok,
  output logic [RB_W-1:0]     status_rb,
  output logic                cp_high
);
  // Named internal events, brought out for the checker
  logic running, tick, start_evt, judge_evt, load_evt;

  vsel_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .run      (running),
    .load_val (settle_len),
    .expired  (tick)
  );

  vsel_step_fsm #(.NBANDS(NBANDS), .DEF_START(DEF_START)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig_wr),
    .auto_en    (auto_en),
    .start_band (start_band),
    .adc_code   (adc_code),
    .tick       (tick),
    .band       (vco_band),
    .running    (running),
    .found      (srch_ok),
    .locked     (lock_ok),
    .start_evt  (start_evt),
    .judge_evt  (judge_evt),
    .load_evt   (load_evt)
  );

  vsel_readback #(.BAND_W(BAND_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .rd_en     (rd_en),
    .rd_hold   (rd_hold),
    .adc_code  (adc_code),
    .band      (vco_band),
    .running   (running),
    .cp_auto   (cp_auto),
    .cp_hi_sel (cp_hi_sel),
    .status    (status_rb),
    .cp_high   (cp_high)
  );

  assign srch_idle = !running;
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker
  import vsel_pkg::*;
#(
  parameter  int NBANDS   = 24,
  parameter  int SETTLE_W = 8,
  localparam int BAND_W   = $clog2(NBANDS),
  localparam int JC_W     = $clog2(NBANDS + 1) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trig_wr,
  input logic                auto_en,
  input logic [CODE_W-1:0]   adc_code,
  input logic [SETTLE_W-1:0] settle_len,
  input logic [BAND_W-1:0]   vco_band,
  input logic                srch_idle,
  input logic                srch_ok,
  input logic                lock_ok,
  input logic                cp_auto,
  input logic                cp_high,
  input logic                start_evt,
  input logic                judge_evt,
  input logic                load_evt
);
  logic [SETTLE_W:0] wait_q;
  logic [JC_W-1:0]   jcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               wait_q <= '0;
    else if (load_evt)        wait_q <= '0;
    else if (wait_q != '1)    wait_q <= wait_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         jcnt_q <= '0;
    else if (start_evt)                 jcnt_q <= '0;
    else if (judge_evt && jcnt_q != '1) jcnt_q <= jcnt_q + 1'b1;
  end

  a_r8_no_ok_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_idle |-> !srch_ok);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && auto_en) |=> !srch_idle);

  a_r11_manual_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> srch_idle);

  a_r3_band_range: assert property (@(posedge clk) disable iff (!rst_n)
    vco_band <= BAND_W'(NBANDS - 1));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!srch_idle && auto_en && !trig_wr) |=>
      (vco_band == $past(vco_band)) ||
      (vco_band == $past(vco_band) + 1'b1) ||
      (vco_band == $past(vco_band) - 1'b1));

  a_r5_ok_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srch_ok) |-> code_stop($past(adc_code)));

  a_r9_lock_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_ok) |-> code_locked($past(adc_code)));

  a_r4_settle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    judge_evt |-> (wait_q == {1'b0, settle_len}));

  a_r7_judge_cap: assert property (@(posedge clk) disable iff (!rst_n)
    judge_evt |-> (jcnt_q < JC_W'(NBANDS)));

  a_r12_cp_follow: assert property (@(posedge clk) disable iff (!rst_n)
    cp_auto |-> (cp_high == !srch_idle));
endmodule

bind vco_band_search vsel_checker #(.NBANDS(NBANDS), .SETTLE_W(SETTLE_W)) u_vsel_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_wr    (trig_wr),
  .auto_en    (auto_en),
  .adc_code   (adc_code),
  .settle_len (settle_len),
  .vco_band   (vco_band),
  .srch_idle  (srch_idle),
  .srch_ok    (srch_ok),
  .lock_ok    (lock_ok),
  .cp_auto    (cp_auto),
  .cp_high    (cp_high),
  .start_evt  (start_evt),
  .judge_evt  (judge_evt),
  .load_evt   (load_evt)
);

// File: tb/test_vco_band_search.sv
module test_vco_band_search;
  localparam int NB = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_wr = 1'b0, auto_en = 1'b0;
  logic [4:0] start_band = 5'd25;
  logic [7:0] settle_len = 8'd0;
  logic [2:0] adc_code;
  logic       rd_en = 1'b0, rd_hold = 1'b0, cp_auto = 1'b0, cp_hi_sel = 1'b0;
  logic [4:0] vco_band;
  logic       srch_idle, srch_ok, lock_ok, cp_high;
  logic [7:0] status_rb;

  always #4 clk = ~clk;

  vco_band_search i_vco_band_search (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .auto_en(auto_en),
    .start_band(start_band), .settle_len(settle_len), .adc_code(adc_code),
    .rd_en(rd_en), .rd_hold(rd_hold), .cp_auto(cp_auto), .cp_hi_sel(cp_hi_sel),
    .vco_band(vco_band), .srch_idle(srch_idle), .srch_ok(srch_ok),
    .lock_ok(lock_ok), .status_rb(status_rb), .cp_high(cp_high)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ADC stimulus: code as a function of the band the design drives
  // mode 0 target, 1 alternate, 2 always 111, 3 always 001, else forced
  int         pmode = 4, ptgt = 0;
  logic       palt = 1'b0;
  logic [2:0] pforce = 3'b000;

  function automatic logic [2:0] pat(input int m, input int t, input logic a,
                                     input logic [2:0] f, input int b);
    case (m)
      0: begin
        if (b == t)     return a ? 3'b101 : 3'b010;
        if (b + 1 == t) return 3'b110;
        if (b < t)      return 3'b111;
        if (b == t + 1) return 3'b001;
        return 3'b000;
      end
      1: return (b % 2 == 1) ? 3'b001 : 3'b110;
      2: return 3'b111;
      3: return 3'b001;
      default: return f;
    endcase
  endfunction

  always_comb adc_code = pat(pmode, ptgt, palt, pforce, int'(vco_band));

  typedef struct {
    int          band;
    int          ok;
    int          lk;
    int unsigned at;
    string       tag;
  } exp_t;

  exp_t q[$];

  // Independent reference: walk the band list until a stop, a rail or the cap
  task automatic predict(input int start, output int band, output int ok,
                         output int lk, output int j);
    int  b, nb;
    bit  done;
    logic [2:0] c;
    b = (start > NB - 1) ? NB - 1 : start;
    ok = 0; lk = 0; j = 0; done = 0;
    while (!done) begin
      c = pat(pmode, ptgt, palt, pforce, b);
      j++;
      if (c == 3'b010 || c == 3'b101) begin
        ok = 1; lk = 1; done = 1;
      end else begin
        lk = (c == 3'b001 || c == 3'b110) ? 1 : 0;
        nb = c[2] ? b + 1 : b - 1;
        if (nb < 0 || nb > NB - 1 || j == NB) done = 1;
        else b = nb;
      end
    end
    band = b;
  endtask

  // Driver: push the expected result, pulse the trigger, wait for the monitor
  task automatic run_search(input string tag, input int start, input int s);
    exp_t e;
    int b, ok, lk, j;
    settle_len = 8'(s);
    start_band = 5'(start);
    predict(start, b, ok, lk, j);
    e.band = b; e.ok = ok; e.lk = lk; e.tag = tag;
    e.at = cyc + 1 + j * (s + 1);
    q.push_back(e);
    trig_wr = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
    chk({tag, " R8 busy after trigger"}, int'(srch_idle), 0);
    if (cp_auto) chk({tag, " R12 cp high while running"}, int'(cp_high), 1);
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pop on each end of search and compare
  initial begin
    logic prev;
    exp_t e;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && srch_idle && !prev && q.size() != 0) begin
        e = q.pop_front();
        chk({e.tag, " R5/R7 final band"}, int'(vco_band), e.band);
        chk({e.tag, " R5/R7 success flag"}, int'(srch_ok), e.ok);
        chk({e.tag, " R9 lock flag"}, int'(lock_ok), e.lk);
        chk({e.tag, " R4 completion cycle"}, int'(cyc), int'(e.at));
      end
      prev = srch_idle;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idle in reset", int'(srch_idle), 1);
    chk("R1 ok in reset", int'(srch_ok), 0);
    chk("R1 lock in reset", int'(lock_ok), 0);
    chk("R1 band in reset", int'(vco_band), 23);
    chk("R1 status in reset", int'(status_rb), 8'hB8);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 manual band follows software
    start_band = 5'd7;
    @(negedge clk);
    chk("R11 manual band", int'(vco_band), 7);
    start_band = 5'd30;
    @(negedge clk);
    chk("R3 manual clamp", int'(vco_band), 23);

    // R2 trigger ignored with automatic selection off
    start_band = 5'd9;
    trig_wr = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
    chk("R2 ignored trigger idle", int'(srch_idle), 1);
    chk("R2 ignored trigger band", int'(vco_band), 9);
    repeat (2) @(negedge clk);
    chk("R2 still idle", int'(srch_idle), 1);

    // R10/R11 manual readback and freeze
    pmode = 4; pforce = 3'b110; rd_en = 1'b1; rd_hold = 1'b0;
    @(negedge clk);
    chk("R11 readback tracks", int'(status_rb), (9 << 3) | 6);
    rd_hold = 1'b1; pforce = 3'b001;
    repeat (2) @(negedge clk);
    chk("R11 readback frozen", int'(status_rb), (9 << 3) | 6);
    rd_en = 1'b0;
    @(negedge clk);
    chk("R11 readback disabled", int'(status_rb), 9 << 3);
    rd_hold = 1'b0;

    // R12 software charge-pump current
    cp_hi_sel = 1'b1;
    @(negedge clk);
    chk("R12 manual cp high", int'(cp_high), 1);
    cp_hi_sel = 1'b0;
    @(negedge clk);
    chk("R12 manual cp low", int'(cp_high), 0);

    auto_en = 1'b1; cp_auto = 1'b1;
    @(negedge clk);

    // R6 upward walk to target
    pmode = 0; ptgt = 14; palt = 1'b0;
    run_search("R6 up-walk", 10, 3);
    chk("R10 status after search", int'(status_rb), (14 << 3) | 2);
    chk("R12 cp low after search", int'(cp_high), 0);

    // R5 downward walk ending on the alternate stop code
    ptgt = 5; palt = 1'b1;
    run_search("R5 down-walk alt code", 20, 0);

    // R3 start clamp
    ptgt = 23; palt = 1'b0;
    run_search("R3 clamp start", 31, 2);

    // R7 run past the top band, unlocked final code
    pmode = 2;
    run_search("R7 top rail", 20, 1);

    // R9 run past band 0 with a locked final code
    pmode = 3;
    run_search("R9 bottom rail", 2, 4);

    // R7 judgement cap with alternating codes
    pmode = 1;
    run_search("R7 judgement cap", 4, 1);

    // R2 abort in the middle of a long settle
    pmode = 0; ptgt = 20; palt = 1'b0;
    settle_len = 8'd50; start_band = 5'd0;
    trig_wr = 1'b1;
    @(negedge clk);
    trig_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 busy before abort", int'(srch_idle), 0);
    auto_en = 1'b0;
    @(negedge clk);
    chk("R2 abort idle", int'(srch_idle), 1);
    chk("R2 abort no success", int'(srch_ok), 0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule